// File: doc/BRIEF.md
# Byte-Read Sample FIFO with Interrupt Request

This block sits between an acquisition engine that produces 16-bit converter samples and a host that reads through an 8-bit port. Each sample enters as one word. The host reads a word in two byte reads, low byte first and then high byte. The word leaves the queue only when its high byte has been read. A read from an empty queue returns the value 0xFF and changes nothing.

The block reports four levels:
- empty
- full, which warns that the next sample will be lost
- threshold reached
- overflow, which stays set until the next completed word read

The threshold register is written at half scale, so the level compared against the occupancy is twice the value written. A single latched interrupt request is raised in one of three ways, chosen by the FIFO enable and scan enable inputs: on every conversion, when the threshold is reached, or at the end of each scan. The request stays set until the host writes the interrupt-reset strobe. A synchronous FIFO reset empties the queue without touching the threshold register.

Top module: `sample_fifo_irq`

## Requirements
- R1: After `rst_n` is asserted, the outputs read: `empty`=1, `full`=0, `thresh`=0, `ovf`=0, `irq`=0, `rd_data`=0xFF and `thr_q`=0.
- R2: Words leave in arrival order. While a word is at the head, the first `rd_en` cycle exposes bits 7:0 on `rd_data`. The next `rd_en` cycle exposes bits 15:8. The word is removed on the cycle that reads its high byte.
- R3: While `empty`=1, `rd_data` is 0xFF, and an `rd_en` cycle changes neither the occupancy nor the byte phase.
- R4: `thr_we` loads `thr_wdata` into `thr_q`. `thresh` is 1 exactly when `thr_q` is nonzero and the occupancy is at least 2*`thr_q`.
- R5: `full` is 1 when the occupancy equals DEPTH. A write while `full`=1 discards the sample, keeps the occupancy and sets `ovf`, even when a pop occurs in the same cycle.
- R6: Once set, `ovf` stays 1 until a cycle that completes a word read (a high-byte read) and carries no overflowing write. That cycle clears it.
- R7: A `fifo_rst` cycle empties the queue, restarts the byte phase at the low byte, and clears `ovf`, which leaves `empty`=1, `thresh`=0 and `full`=0. Writes and reads in that cycle are ignored, and `thr_q` is kept.
- R8: With `scan_en`=0 and `fifo_en`=0, every sample write (`wr_en` outside a `fifo_rst` cycle, even a discarded one) sets `irq`.
- R9: With `scan_en`=0 and `fifo_en`=1, `irq` is set only by an accepted write, without a same-cycle pop, that raises the occupancy to exactly 2*`thr_q`, where `thr_q` is nonzero.
- R10: With `scan_en`=1, only a sample write that carries `scan_last`=1 sets `irq`, whatever the value of `fifo_en`.
- R11: `irq` is set on the cycle after its event and stays set until an `irq_clr` cycle. If a new event arrives in the same cycle as `irq_clr`, `irq` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Selects threshold interrupt mode |
| scan_en | input | 1 | Selects end-of-scan interrupt mode |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | 16 | Sample word |
| scan_last | input | 1 | Marks the written sample as the last of its scan |
| rd_en | input | 1 | Host byte read strobe |
| rd_data | output | 8 | Byte at the head of the queue, 0xFF when empty |
| thr_we | input | 1 | Threshold register write strobe |
| thr_wdata | input | TW | Half-scale threshold value |
| thr_q | output | TW | Threshold register readback |
| fifo_rst | input | 1 | Synchronous FIFO reset |
| irq_clr | input | 1 | Interrupt-reset strobe |
| empty | output | 1 | Queue is empty |
| thresh | output | 1 | Occupancy at or above twice `thr_q` |
| full | output | 1 | Occupancy equals DEPTH |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Latched interrupt request |

## Verification
The interrupt logic is tried in each of its three modes with the same kinds of traffic:
- plain writes
- writes marked as the end of a scan
- writes that cross the doubled threshold

This separates which condition raises `irq` in each mode. Filling a small queue to DEPTH and then writing once more checks the full flag, the discarded sample and the overflow flag. Reading one byte and then the other checks that overflow clears only when a whole word is read. A FIFO reset issued between the two byte reads shows that the byte phase restarts. A long seeded random mix of writes, reads, resets, threshold changes and enable changes is compared every cycle against a reference queue kept by the bench.

// File: rtl/sample_fifo_irq.sv
module sample_fifo_irq #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int TW = AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          scan_en,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  input  logic          scan_last,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          thr_we,
  input  logic [TW-1:0] thr_wdata,
  output logic [TW-1:0] thr_q,
  input  logic          fifo_rst,
  input  logic          irq_clr,
  output logic          empty,
  output logic          thresh,
  output logic          full,
  output logic          ovf,
  output logic          irq
);
  // DEPTH must be a power of two: the pointers wrap by overflow.
  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          hi;
  logic          wr, push, rd_ok, pop, ev;
  logic [AW:0]   eff;

  assign eff    = {thr_q, 1'b0};
  assign empty  = (cnt == '0);
  assign full   = (cnt == (AW+1)'(DEPTH));
  assign thresh = (eff != '0) && (cnt >= eff);

  assign wr    = wr_en & ~fifo_rst;
  assign push  = wr & ~full;
  assign rd_ok = rd_en & ~empty & ~fifo_rst;
  assign pop   = rd_ok & hi;

  assign rd_data = empty ? 8'hFF : (hi ? mem[rp][15:8] : mem[rp][7:0]);

  always_comb begin
    if (scan_en)      ev = wr & scan_last;
    else if (fifo_en) ev = push & ~pop & (eff != '0) & ((cnt + (AW+1)'(1)) == eff);
    else              ev = wr;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      hi    <= 1'b0;
      ovf   <= 1'b0;
      irq   <= 1'b0;
      thr_q <= '0;
    end else begin
      if (thr_we) thr_q <= thr_wdata;
      irq <= ev | (irq & ~irq_clr);
      if (fifo_rst) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
        hi  <= 1'b0;
        ovf <= 1'b0;
      end else begin
        if (push)  wp <= wp + AW'(1);
        if (pop)   rp <= rp + AW'(1);
        cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
        if (rd_ok) hi <= ~hi;
        if (wr & full) ovf <= 1'b1;
        else if (pop)  ovf <= 1'b0;
      end
    end
  end

  p_reset_state_r1: assert property (@(posedge clk) $rose(rst_n) |-> empty && !irq && !ovf);
  p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_en && !wr_en |=> empty);
  p_thresh_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    thresh |-> !empty);
  p_full_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_en && !fifo_rst |=> full && ovf);
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !rd_en && !fifo_rst |=> ovf);
  p_fifo_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> empty && !full && !thresh && !ovf);
  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
endmodule

// File: tb/sample_fifo_irq_tb.sv
`timescale 1ns/1ps
module sample_fifo_irq_tb;
  localparam int DEPTH = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, fifo_en, scan_en, wr_en, scan_last, rd_en, thr_we, fifo_rst, irq_clr;
  logic [15:0] wr_data;
  logic [TW-1:0] thr_wdata, thr_q;
  logic [7:0] rd_data;
  logic empty, thresh, full, ovf, irq;

  sample_fifo_irq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .scan_en(scan_en),
    .wr_en(wr_en), .wr_data(wr_data), .scan_last(scan_last),
    .rd_en(rd_en), .rd_data(rd_data), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .thr_q(thr_q), .fifo_rst(fifo_rst), .irq_clr(irq_clr), .empty(empty),
    .thresh(thresh), .full(full), .ovf(ovf), .irq(irq));

  int checks = 0, fails = 0;
  logic [15:0] mq[$];
  bit m_hi, m_ovf, m_irq;
  logic [TW-1:0] m_thr;

  function automatic logic [7:0] exp_rd();
    if (mq.size() == 0) return 8'hFF;
    return m_hi ? mq[0][15:8] : mq[0][7:0];
  endfunction

  function automatic bit exp_thresh();
    int eff = 2 * int'(m_thr);
    return (eff != 0) && (mq.size() >= eff);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit wr, mfull, pop, ev;
    int eff;
    wr = wr_en && !fifo_rst;
    mfull = (mq.size() == DEPTH);
    pop = rd_en && !fifo_rst && mq.size() != 0 && m_hi;
    eff = 2 * int'(m_thr);
    if (scan_en) ev = wr && scan_last;
    else if (fifo_en) ev = wr && !mfull && !pop && eff != 0 && mq.size() + 1 == eff;
    else ev = wr;
    m_irq = ev || (m_irq && !irq_clr);
    if (thr_we) m_thr = thr_wdata;
    if (fifo_rst) begin
      mq.delete();
      m_hi = 0;
      m_ovf = 0;
    end else begin
      if (wr && mfull) m_ovf = 1;
      else if (pop) m_ovf = 0;
      if (rd_en && mq.size() != 0) m_hi = !m_hi;
      if (pop) void'(mq.pop_front());
      if (wr && !mfull) mq.push_back(wr_data);
    end
  endtask

  task automatic compare_all();
    chk("R2 rd_data", rd_data, exp_rd());
    chk("R5 empty", empty, mq.size() == 0);
    chk("R5 full", full, mq.size() == DEPTH);
    chk("R4 thresh", thresh, exp_thresh());
    chk("R6 ovf", ovf, m_ovf);
    chk("R11 irq", irq, m_irq);
    chk("R4 thr_q", thr_q, m_thr);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    compare_all();
  endtask

  task automatic put(logic [15:0] v, bit last);
    wr_en = 1; wr_data = v; scan_last = last;
    cyc();
    wr_en = 0; scan_last = 0;
  endtask

  task automatic rd1();
    rd_en = 1; cyc(); rd_en = 0;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 0; fifo_en = 0; scan_en = 0; wr_en = 0; wr_data = '0; scan_last = 0;
    rd_en = 0; thr_we = 0; thr_wdata = '0; fifo_rst = 0; irq_clr = 0;
    m_hi = 0; m_ovf = 0; m_irq = 0; m_thr = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    // R1 reset state
    chk("R1 empty", empty, 1); chk("R1 full", full, 0); chk("R1 thresh", thresh, 0);
    chk("R1 ovf", ovf, 0); chk("R1 irq", irq, 0); chk("R1 rd_data", rd_data, 8'hFF);
    chk("R1 thr_q", thr_q, 0);
    // R3 empty read
    rd1();
    chk("R3 rd_data", rd_data, 8'hFF); chk("R3 empty", empty, 1);
    // R4 / R9 threshold mode, effective level 6
    fifo_en = 1; thr_we = 1; thr_wdata = 4'd3; cyc(); thr_we = 0;
    chk("R4 thr_q", thr_q, 3);
    for (int i = 0; i < 5; i++) put(16'h1234 + 16'(i * 16'h0101), 0);
    chk("R4 thresh below", thresh, 0); chk("R9 irq below", irq, 0);
    put(16'h1739, 0);
    chk("R4 thresh at", thresh, 1); chk("R9 irq at", irq, 1);
    cyc();
    chk("R11 irq held", irq, 1);
    irq_clr = 1; cyc(); irq_clr = 0;
    chk("R11 irq cleared", irq, 0);
    // R2 byte order
    chk("R2 low", rd_data, 8'h34);
    rd1(); chk("R2 high", rd_data, 8'h12); chk("R2 not popped", empty, 0);
    rd1(); chk("R2 next low", rd_data, 8'h35);
    // R5 / R6 full and overflow
    fifo_rst = 1; cyc(); fifo_rst = 0;
    for (int i = 0; i < DEPTH; i++) put(16'hA000 + 16'(i), 0);
    chk("R5 full", full, 1); chk("R5 ovf clear", ovf, 0);
    put(16'hBEEF, 0);
    chk("R5 ovf set", ovf, 1); chk("R5 still full", full, 1);
    rd1(); chk("R6 ovf after low byte", ovf, 1);
    rd1(); chk("R6 ovf after word", ovf, 0); chk("R6 popped", full, 0);
    // R7 reset mid-word
    rd1();
    chk("R7 at high", rd_data, 8'hA0);
    fifo_rst = 1; cyc(); fifo_rst = 0;
    chk("R7 empty", empty, 1); chk("R7 thresh", thresh, 0); chk("R7 full", full, 0);
    chk("R7 thr kept", thr_q, 3);
    put(16'h5AC3, 0);
    chk("R7 phase restart", rd_data, 8'hC3);
    // R8 per-conversion mode
    fifo_en = 0; irq_clr = 1; cyc(); irq_clr = 0;
    chk("R8 idle", irq, 0);
    put(16'h0001, 0);
    chk("R8 irq", irq, 1);
    // R10 scan mode
    scan_en = 1; irq_clr = 1; cyc(); irq_clr = 0;
    put(16'h0002, 0);
    chk("R10 mid scan", irq, 0);
    put(16'h0003, 1);
    chk("R10 scan end", irq, 1);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      wr_en = ($urandom % 2) == 0;
      wr_data = 16'($urandom);
      scan_last = ($urandom % 4) == 0;
      rd_en = ($urandom % 2) == 0;
      fifo_rst = ($urandom % 60) == 0;
      irq_clr = ($urandom % 5) == 0;
      thr_we = ($urandom % 25) == 0;
      thr_wdata = 4'($urandom % 9);
      if ($urandom % 100 == 0) fifo_en = ~fifo_en;
      if ($urandom % 150 == 0) scan_en = ~scan_en;
      cyc();
    end
    wr_en = 0; rd_en = 0; fifo_rst = 0; irq_clr = 0; thr_we = 0;
    finish_run();
  end
endmodule